// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block keeps the interrupt enable bits and the pending-event flags for an 8-bit timer with one output-compare channel and overflow detection. The timer core feeds it single-cycle event strobes: a compare match, a wrap of the counter in normal counting, and a turn from down-counting to up-counting at zero in phase-correct PWM counting. A mode input selects which of the last two strobes counts as an overflow.

Software reaches two byte-wide registers over a simple register bus. The enable register lives at address 0 and the flag register at address 1. A flag clears when software writes a one to its bit, or when the interrupt controller acknowledges the vector with a one-cycle pulse. Each source raises a registered request while the global interrupt enable, its enable bit and its flag are all one.

Top module: `tif_unit`

## Requirements
- R1: After reset both registers read 0x00 and both request outputs are low.
- R2: The enable register (address 0) holds the compare enable at bit 1 and the overflow enable at bit 0. Bits 7..2 read as zero, and writes to them have no effect.
- R3: The flag register (address 1) holds the compare flag at bit 1 and the overflow flag at bit 0. Bits 7..2 always read as zero.
- R4: A compare-match strobe sets the compare flag at the next rising clock edge.
- R5: With phase_mode low, a wrap strobe sets the overflow flag and a bottom-turn strobe is ignored.
- R6: With phase_mode high, a bottom-turn strobe sets the overflow flag and a wrap strobe is ignored.
- R7: Writing a one to a flag bit clears that flag. Writing a zero leaves it unchanged.
- R8: An acknowledge pulse clears only the flag of its own source.
- R9: When a set strobe and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R10: A request output goes high one clock after the global enable, its enable bit and its flag are all one, and drops one clock after any of the three goes low.
- R11: Read data is 0x00 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gie | input | 1 | Global interrupt enable |
| phase_mode | input | 1 | 1 selects phase-correct overflow signalling |
| ev_match | input | 1 | Compare-match strobe |
| ev_wrap | input | 1 | Counter wrap strobe (normal mode) |
| ev_bottom | input | 1 | Down-to-up turn at zero strobe (phase-correct mode) |
| ack_match | input | 1 | Compare vector acknowledge pulse |
| ack_ovf | input | 1 | Overflow vector acknowledge pulse |
| bus_addr | input | 1 | Register select: 0 enable, 1 flag |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq_match | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
A flag that stuck or was lost shows up on the flag register read at once, and on the request output one clock later once the enables are set. A wrong enable bit shows on the enable register read and silences or falsely raises a request within one clock. A bad overflow source mux shows as a flag that appears on the wrong strobe for the selected mode. Resolving a set against a clear in the wrong order shows as a cleared flag right after the collision cycle.

// File: rtl/tif_pkg.sv
package tif_pkg;
   localparam int unsigned NSRC    = 2;
   localparam int unsigned SRC_OVF = 0;
   localparam int unsigned SRC_CMP = 1;

   typedef enum logic {
      REG_ENABLE = 1'b0,
      REG_FLAG   = 1'b1
   } reg_sel_e;

   typedef struct packed {
      logic cmp;
      logic ovf;
   } src_vec_t;
endpackage

// File: rtl/tif_ovf_select.sv
module tif_ovf_select #(
   parameter bit HAS_PHASE = 1'b1
) (
   input  logic phase_mode,
   input  logic ev_wrap,
   input  logic ev_bottom,
   output logic ovf_evt
);
   generate
      if (HAS_PHASE) begin : g_phase
         always_comb ovf_evt = phase_mode ? ev_bottom : ev_wrap;
      end else begin : g_normal
         logic unused_sig;
         always_comb unused_sig = phase_mode ^ ev_bottom;
         always_comb ovf_evt = ev_wrap;
      end
   endgenerate
endmodule

// File: rtl/tif_flag_cell.sv
module tif_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      q <= 1'b0;
      else if (set_i)  q <= 1'b1;
      else if (clr_i)  q <= 1'b0;
   end
endmodule

// File: rtl/tif_irq_gate.sv
module tif_irq_gate #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         gie,
   input  logic [N-1:0] en,
   input  logic [N-1:0] flag,
   output logic [N-1:0] irq
);
   logic [N-1:0] irq_d;
   always_comb irq_d = gie ? (en & flag) : '0;
   always_ff @(posedge clk) begin
      if (!rst_n) irq <= '0;
      else        irq <= irq_d;
   end
endmodule

// File: rtl/tif_unit.sv
module tif_unit
   import tif_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter bit          HAS_PHASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gie,
   input  logic              phase_mode,
   input  logic              ev_match,
   input  logic              ev_wrap,
   input  logic              ev_bottom,
   input  logic              ack_match,
   input  logic              ack_ovf,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_match,
   output logic              irq_ovf
);
   localparam int unsigned PAD_W = DATA_W - NSRC;

   initial begin
      if (DATA_W < NSRC)
         $error("tif_unit: DATA_W must hold all %0d source bits", NSRC);
      if (DATA_W > 32)
         $error("tif_unit: DATA_W above 32 is not supported");
   end

   logic [NSRC-1:0] en_q;
   logic [NSRC-1:0] flag_q;
   logic [NSRC-1:0] set_v;
   logic [NSRC-1:0] ack_v;
   logic [NSRC-1:0] wclr_v;
   logic [NSRC-1:0] irq_v;
   logic            ovf_evt;
   logic            wr_en;
   logic            wr_flag;
   logic            unused_wdata;

   tif_ovf_select #(.HAS_PHASE(HAS_PHASE)) u_ovf_sel (
      .phase_mode (phase_mode),
      .ev_wrap    (ev_wrap),
      .ev_bottom  (ev_bottom),
      .ovf_evt    (ovf_evt)
   );

   always_comb begin
      wr_en   = bus_wr && (reg_sel_e'(bus_addr) == REG_ENABLE);
      wr_flag = bus_wr && (reg_sel_e'(bus_addr) == REG_FLAG);
      set_v          = '0;
      ack_v          = '0;
      set_v[SRC_CMP] = ev_match;
      set_v[SRC_OVF] = ovf_evt;
      ack_v[SRC_CMP] = ack_match;
      ack_v[SRC_OVF] = ack_ovf;
      wclr_v         = wr_flag ? bus_wdata[NSRC-1:0] : '0;
      unused_wdata   = ^bus_wdata[DATA_W-1:NSRC];
   end

   // enable bits: plain storage, reserved positions dropped
   always_ff @(posedge clk) begin
      if (!rst_n)     en_q <= '0;
      else if (wr_en) en_q <= bus_wdata[NSRC-1:0];
   end

   genvar gi;
   generate
      for (gi = 0; gi < NSRC; gi++) begin : g_src
         tif_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[gi]),
            .clr_i (wclr_v[gi] | ack_v[gi]),
            .q     (flag_q[gi])
         );
      end
   endgenerate

   tif_irq_gate #(.N(NSRC)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .gie   (gie),
      .en    (en_q),
      .flag  (flag_q),
      .irq   (irq_v)
   );

   always_comb begin
      irq_match = irq_v[SRC_CMP];
      irq_ovf   = irq_v[SRC_OVF];
      bus_rdata = '0;
      if (bus_rd) begin
         if (reg_sel_e'(bus_addr) == REG_ENABLE)
            bus_rdata = {{PAD_W{1'b0}}, en_q};
         else
            bus_rdata = {{PAD_W{1'b0}}, flag_q};
      end
   end
endmodule

// File: rtl/tif_unit_chk.sv
module tif_unit_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gie,
   input logic              phase_mode,
   input logic              ev_match,
   input logic              ev_bottom,
   input logic              ack_match,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [1:0]        en_q,
   input logic [1:0]        flag_q,
   input logic              irq_match
);
   // R4
   match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_match |=> flag_q[1]);
   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_match && ack_match) |=> flag_q[1]);
   // R8
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_match && !ev_match) |=> !flag_q[1]);
   // R6
   phase_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_mode && ev_bottom) |=> flag_q[0]);
   // R10
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gie && en_q[1] && flag_q[1]) |=> irq_match);
   // R10
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gie && en_q[1] && flag_q[1]) |=> !irq_match);
   // R11
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));
   // R3
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:2] == '0);
endmodule

bind tif_unit tif_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gie        (gie),
   .phase_mode (phase_mode),
   .ev_match   (ev_match),
   .ev_bottom  (ev_bottom),
   .ack_match  (ack_match),
   .bus_rd     (bus_rd),
   .bus_rdata  (bus_rdata),
   .en_q       (en_q),
   .flag_q     (flag_q),
   .irq_match  (irq_match)
);

// File: tb/tif_unit_test.sv
`timescale 1ns/1ps
module tif_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gie = 1'b0, phase_mode = 1'b0;
   logic       ev_match = 1'b0, ev_wrap = 1'b0, ev_bottom = 1'b0;
   logic       ack_match = 1'b0, ack_ovf = 1'b0;
   logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_match, irq_ovf;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tif_unit uut (.*);

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0; bus_wdata = 8'h00;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input logic m, input logic w, input logic b,
                        input logic am, input logic ao);
      @(negedge clk);
      ev_match = m; ev_wrap = w; ev_bottom = b; ack_match = am; ack_ovf = ao;
      @(negedge clk);
      ev_match = 0; ev_wrap = 0; ev_bottom = 0; ack_match = 0; ack_ovf = 0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(1'b0, d); check("R1 enable after reset", d, 8'h00);
      rd(1'b1, d); check("R1 flags after reset", d, 8'h00);
      check("R1 irqs after reset", {6'd0, irq_match, irq_ovf}, 8'h00);
      #1 check("R11 idle read data", bus_rdata, 8'h00);
   endtask

   task automatic t_enable();
      logic [7:0] d;
      wr(1'b0, 8'hFF); rd(1'b0, d); check("R2 reserved enable bits", d, 8'h03);
      wr(1'b0, 8'hFD); rd(1'b0, d); check("R2 enable write", d, 8'h01);
      wr(1'b0, 8'h00);
   endtask

   task automatic t_match();
      logic [7:0] d;
      pulse(1, 0, 0, 0, 0); rd(1'b1, d); check("R4 R3 match flag bit1", d, 8'h02);
      wr(1'b1, 8'hFC); rd(1'b1, d); check("R7 write zero keeps flag", d, 8'h02);
      wr(1'b1, 8'h02); rd(1'b1, d); check("R7 write one clears flag", d, 8'h00);
   endtask

   task automatic t_normal();
      logic [7:0] d;
      phase_mode = 1'b0;
      pulse(0, 0, 1, 0, 0); rd(1'b1, d); check("R5 bottom ignored in normal", d, 8'h00);
      pulse(0, 1, 0, 0, 0); rd(1'b1, d); check("R5 wrap sets overflow", d, 8'h01);
      wr(1'b1, 8'h01); rd(1'b1, d); check("R7 overflow cleared", d, 8'h00);
   endtask

   task automatic t_phase();
      logic [7:0] d;
      phase_mode = 1'b1;
      pulse(0, 1, 0, 0, 0); rd(1'b1, d); check("R6 wrap ignored in phase", d, 8'h00);
      pulse(0, 0, 1, 0, 0); rd(1'b1, d); check("R6 bottom sets overflow", d, 8'h01);
      wr(1'b1, 8'h01);
      phase_mode = 1'b0;
   endtask

   task automatic t_ack();
      logic [7:0] d;
      pulse(1, 1, 0, 0, 0); rd(1'b1, d); check("R4 both flags set", d, 8'h03);
      pulse(0, 0, 0, 1, 0); rd(1'b1, d); check("R8 ack clears match only", d, 8'h01);
      pulse(0, 0, 0, 0, 1); rd(1'b1, d); check("R8 ack clears overflow", d, 8'h00);
   endtask

   task automatic t_setwins();
      logic [7:0] d;
      pulse(1, 0, 0, 1, 0); rd(1'b1, d); check("R9 set beats ack", d, 8'h02);
      wr(1'b1, 8'h02);
      @(negedge clk);
      bus_addr = 1'b1; bus_wdata = 8'h01; bus_wr = 1'b1; ev_wrap = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 8'h00; ev_wrap = 1'b0;
      rd(1'b1, d); check("R9 set beats write-one", d, 8'h01);
      wr(1'b1, 8'h03);
   endtask

   task automatic t_irq();
      wr(1'b0, 8'h03); gie = 1'b1;
      pulse(1, 0, 0, 0, 0);
      check("R10 irq not yet after flag", {7'd0, irq_match}, 8'h00);
      @(negedge clk);
      check("R10 irq one cycle after flag", {7'd0, irq_match}, 8'h01);
      gie = 1'b0; @(negedge clk);
      check("R10 irq drops with gie", {7'd0, irq_match}, 8'h00);
      wr(1'b0, 8'h01); gie = 1'b1; @(negedge clk); @(negedge clk);
      check("R10 irq masked by enable", {6'd0, irq_match, irq_ovf}, 8'h00);
      pulse(0, 1, 0, 0, 0); @(negedge clk);
      check("R10 overflow irq", {6'd0, irq_match, irq_ovf}, 8'h01);
      pulse(0, 0, 0, 0, 1); @(negedge clk);
      check("R10 irq drops after ack", {6'd0, irq_match, irq_ovf}, 8'h00);
      gie = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable();
      t_match();
      t_normal();
      t_phase();
      t_ack();
      t_setwins();
      t_irq();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule